// File: doc/BRIEF.md
# Quad-IO Continuous-Read Memory Target

This block is the device end of a four-line serial memory link. A host lowers chip select and clocks a read command in. The command carries an op-code, a byte address, a mode byte and a few wait clocks, and the block then returns bytes four bits at a time. It reads every byte through a one-cycle synchronous read port into a backing array that sits outside the block. While chip select stays low, the block keeps stepping to the next address, and it wraps from the top of the array back to zero.

A mode byte of 0xEF or 0xAF leaves the block in continuous-read state. The next select-low transaction then starts straight at the address, with no op-code. Any other mode value returns the block to normal op-code decoding at the end of the transaction. Two other op-codes switch a quad op-code flag on and off. While that flag is set, op-codes arrive four bits per clock.

After reset, the read op-code is refused until some other complete op-code has been received. All link inputs are oversampled on the system clock `clk`, so SCK must run at most at one eighth of that clock.

Top module: `qxr_target`

## Requirements
- R1: After reset, io_oe is 0, abort_err is 0 and mem_rd_en is 0. io_oe is always either 0000 or 1111.
- R2: With the quad flag clear, op-code 0xEB is taken MSB first on io_in[0], one bit per SCK rising edge, 8 edges. Then 6 address nibbles and 2 mode nibbles follow on io_in[3:0], most significant nibble first, one per rising edge, with io_in[3] the top bit of each nibble.
- R3: Only the low ADDR_W (19) bits of the 24-bit address are used. The upper 5 bits have no effect on which byte is returned.
- R4: The number of wait clocks after the mode byte is set by lat_sel: 0→2, 1→4, 2→6, 3→6. io_oe stays 0 through the op-code, address, mode and wait phases. It turns on at the first SCK falling edge after the last wait rising edge.
- R5: Data is driven on SCK falling edges, high nibble of each byte first. Each byte comes from the current address, the next byte from the address plus one, and the address wraps from 2^ADDR_W-1 to 0.
- R6: A byte fetch raises mem_rd_en for one clk cycle with the address on mem_addr. mem_rd_data is taken one clk cycle later.
- R7: A mode byte of 0xEF or 0xAF makes the next select-low transaction begin directly with the 6 address nibbles.
- R8: Any other mode byte returns the block to op-code decoding when chip select next rises.
- R9: A chip-select rise during the data phase ends the transaction: io_oe returns to 0 within 4 clk cycles and abort_err stays 0.
- R10: Until a complete op-code other than 0xEB has been received after reset, op-code 0xEB is ignored: no fetch and io_oe stays 0.
- R11: Op-code 0x38 sets the quad flag and 0xFF clears it. While the flag is set, op-codes arrive as 2 nibbles on io_in[3:0], high nibble first.
- R12: A chip-select rise during the mode or wait phase ends the transaction, pulses abort_err for exactly one clk cycle and clears continuous-read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| io_in | input | 4 | Sampled level of the four IO lines |
| lat_sel | input | 2 | Wait-clock count select |
| io_out | output | 4 | Nibble driven onto the IO lines |
| io_oe | output | 4 | Output enable for each IO line |
| mem_rd_en | output | 1 | Backing-array read strobe |
| mem_addr | output | ADDR_W | Backing-array byte address |
| mem_rd_data | input | 8 | Backing-array read data, one cycle after the strobe |
| abort_err | output | 1 | One-cycle pulse on a select rise during mode or wait |

## Verification
A phase counter that is off by one shifts every returned nibble. Because the backing pattern differs at every address, this shows up on the very first data sample of the transaction. Wrong continuous-read or quad-flag state does not show in the transaction that sets it. It shows in the next one: an op-code is taken as address nibbles, or the reverse, and the returned bytes come from the wrong place. A wrong arming state shows as fetch strobes and enabled outputs on a read that should have been ignored.

// File: rtl/qxr_pkg.sv
package qxr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_MODE,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_QREAD    = 8'hEB;
  localparam logic [7:0] OP_QUAD_ON  = 8'h38;
  localparam logic [7:0] OP_QUAD_OFF = 8'hFF;
  localparam logic [7:0] MODE_STAY_A = 8'hEF;
  localparam logic [7:0] MODE_STAY_B = 8'hAF;

  // wait clocks selected by the latency field
  function automatic logic [2:0] dummy_cycles(input logic [1:0] lat);
    case (lat)
      2'd0:    dummy_cycles = 3'd2;
      2'd1:    dummy_cycles = 3'd4;
      default: dummy_cycles = 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/qxr_rst_sync.sv
module qxr_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) ff_q <= 2'b00;
    else          ff_q <= {ff_q[0], 1'b1};
  end

  assign rst_n_o = ff_q[1];
endmodule

// File: rtl/qxr_in_sync.sv
module qxr_in_sync #(
  parameter int              W       = 6,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign st_d[g] = d_i;
    end else begin : g_tail
      assign st_d[g] = st_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/qxr_fetch.sv
module qxr_fetch #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              next_i,
  input  logic              drive_hi_i,
  input  logic              drive_lo_i,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic [3:0]        nib_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              pend_q;
  logic [7:0]        byte_q, byte_d;
  logic [3:0]        nib_q, nib_d;

  always_comb begin
    addr_d = addr_q;
    if (start_i)     addr_d = start_addr_i;
    else if (next_i) addr_d = addr_q + 1'b1;
    rd_d   = start_i | next_i;
    byte_d = pend_q ? mem_rd_data : byte_q;
    nib_d  = nib_q;
    if (drive_hi_i)      nib_d = byte_q[7:4];
    else if (drive_lo_i) nib_d = byte_q[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      pend_q <= 1'b0;
      byte_q <= '0;
      nib_q  <= '0;
    end else begin
      addr_q <= addr_d;
      rd_q   <= rd_d;
      pend_q <= rd_q;
      byte_q <= byte_d;
      nib_q  <= nib_d;
    end
  end

  assign mem_rd_en = rd_q;
  assign mem_addr  = addr_q;
  assign nib_o     = nib_q;
endmodule

// File: rtl/qxr_target.sv
module qxr_target
  import qxr_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [3:0]        io_in,
  input  logic [1:0]        lat_sel,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              abort_err
);
  localparam int SH_W = ADDR_W - 4;
  localparam int IN_W = 6;

  logic            rst_n_s;
  logic [IN_W-1:0] raw_v, syn_v;
  logic            cs_s, sck_s;
  logic [3:0]      io_s;
  logic            cs_d_q, sck_d_q;
  logic            cs_rise, cs_fall, sck_rise, sck_fall;

  phase_t          phase_q, phase_d;
  logic [2:0]      cnt_q, cnt_d;
  logic [2:0]      dum_q, dum_d;
  logic [SH_W-1:0] sh_q, sh_d;
  logic            qpi_q, qpi_d;
  logic            armed_q, armed_d;
  logic            xip_q, xip_d;
  logic            keep_q, keep_d;
  logic            oe_q, oe_d;
  logic            hi_q, hi_d;
  logic            err_q, err_d;

  logic [ADDR_W-1:0] sh_nib;
  logic [7:0]        opc_nxt;
  logic              opc_last;
  logic              fetch_start, fetch_next, drive_hi, drive_lo;

  qxr_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign raw_v = {cs_n, sck, io_in};

  qxr_in_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (6'b10_0000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (raw_v),
    .q_o   (syn_v)
  );

  assign cs_s  = syn_v[5];
  assign sck_s = syn_v[4];
  assign io_s  = syn_v[3:0];

  assign cs_rise  =  cs_s  & ~cs_d_q;
  assign cs_fall  = ~cs_s  &  cs_d_q;
  assign sck_rise =  sck_s & ~sck_d_q & ~cs_s;
  assign sck_fall = ~sck_s &  sck_d_q & ~cs_s;

  assign sh_nib   = {sh_q, io_s};
  assign opc_nxt  = qpi_q ? {sh_q[3:0], io_s} : {sh_q[6:0], io_s[0]};
  assign opc_last = qpi_q ? (cnt_q == 3'd1) : (cnt_q == 3'd7);

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    dum_d       = dum_q;
    sh_d        = sh_q;
    qpi_d       = qpi_q;
    armed_d     = armed_q;
    xip_d       = xip_q;
    keep_d      = keep_q;
    oe_d        = oe_q;
    hi_d        = hi_q;
    err_d       = 1'b0;
    fetch_start = 1'b0;
    fetch_next  = 1'b0;
    drive_hi    = 1'b0;
    drive_lo    = 1'b0;

    if (cs_rise) begin
      oe_d    = 1'b0;
      phase_d = PH_IDLE;
      if (phase_q == PH_MODE || phase_q == PH_DUMMY) begin
        xip_d = 1'b0;
        err_d = 1'b1;
      end else if (phase_q == PH_DATA) begin
        xip_d = keep_q;
      end
    end else if (cs_fall) begin
      phase_d = xip_q ? PH_ADDR : PH_OPC;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (sck_rise) begin
      case (phase_q)
        PH_OPC: begin
          sh_d  = {{(SH_W-8){1'b0}}, opc_nxt};
          cnt_d = cnt_q + 3'd1;
          if (opc_last) begin
            cnt_d = '0;
            sh_d  = '0;
            if (opc_nxt == OP_QREAD) begin
              phase_d = armed_q ? PH_ADDR : PH_SKIP;
            end else begin
              phase_d = PH_SKIP;
              armed_d = 1'b1;
              if (opc_nxt == OP_QUAD_ON)  qpi_d = 1'b1;
              if (opc_nxt == OP_QUAD_OFF) qpi_d = 1'b0;
            end
          end
        end
        PH_ADDR: begin
          sh_d  = sh_nib[SH_W-1:0];
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd5) begin
            cnt_d       = '0;
            phase_d     = PH_MODE;
            fetch_start = 1'b1;
          end
        end
        PH_MODE: begin
          sh_d  = sh_nib[SH_W-1:0];
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd1) begin
            cnt_d   = '0;
            keep_d  = (sh_nib[7:0] == MODE_STAY_A) || (sh_nib[7:0] == MODE_STAY_B);
            dum_d   = dummy_cycles(lat_sel);
            phase_d = PH_DUMMY;
          end
        end
        PH_DUMMY: begin
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == dum_q - 3'd1) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
            hi_d    = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (sck_fall && phase_q == PH_DATA) begin
      oe_d = 1'b1;
      hi_d = ~hi_q;
      if (hi_q) begin
        drive_hi = 1'b1;
      end else begin
        drive_lo   = 1'b1;
        fetch_next = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_d_q  <= 1'b1;
      sck_d_q <= 1'b0;
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dum_q   <= 3'd2;
      sh_q    <= '0;
      qpi_q   <= 1'b0;
      armed_q <= 1'b0;
      xip_q   <= 1'b0;
      keep_q  <= 1'b0;
      oe_q    <= 1'b0;
      hi_q    <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      cs_d_q  <= cs_s;
      sck_d_q <= sck_s;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      dum_q   <= dum_d;
      sh_q    <= sh_d;
      qpi_q   <= qpi_d;
      armed_q <= armed_d;
      xip_q   <= xip_d;
      keep_q  <= keep_d;
      oe_q    <= oe_d;
      hi_q    <= hi_d;
      err_q   <= err_d;
    end
  end

  qxr_fetch #(
    .ADDR_W (ADDR_W)
  ) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (fetch_start),
    .start_addr_i (sh_nib),
    .next_i       (fetch_next),
    .drive_hi_i   (drive_hi),
    .drive_lo_i   (drive_lo),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .mem_rd_data  (mem_rd_data),
    .nib_o        (io_out)
  );

  assign io_oe     = {4{oe_q}};
  assign abort_err = err_q;
endmodule

// File: rtl/qxr_target_chk.sv
module qxr_target_chk
  import qxr_pkg::*;
(
  input logic       clk,
  input logic       rst_n_s,
  input logic       cs_s,
  input phase_t     phase_q,
  input logic       armed_q,
  input logic       xip_q,
  input logic [3:0] io_oe,
  input logic       mem_rd_en,
  input logic       abort_err
);
  a_r1_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n_s)
    (io_oe == 4'h0) || (io_oe == 4'hF));

  a_r4_oe_only_in_data: assert property (@(posedge clk) disable iff (!rst_n_s)
    (io_oe != 4'h0) |-> (phase_q == PH_DATA));

  a_r9_oe_off_cs_high: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_s |=> (io_oe == 4'h0));

  a_r10_no_fetch_unarmed: assert property (@(posedge clk) disable iff (!rst_n_s)
    !armed_q |-> !mem_rd_en);

  a_r7_xip_needs_armed: assert property (@(posedge clk) disable iff (!rst_n_s)
    xip_q |-> armed_q);

  a_r12_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_s)
    abort_err |=> !abort_err);

  a_r12_err_clears_xip: assert property (@(posedge clk) disable iff (!rst_n_s)
    abort_err |-> !xip_q);
endmodule

bind qxr_target qxr_target_chk u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cs_s      (cs_s),
  .phase_q   (phase_q),
  .armed_q   (armed_q),
  .xip_q     (xip_q),
  .io_oe     (io_oe),
  .mem_rd_en (mem_rd_en),
  .abort_err (abort_err)
);

// File: tb/qxr_target_tb_top.sv
`timescale 1ns/1ps
module qxr_target_tb_top;
  localparam int ADDR_W = 19;
  localparam int HALF   = 5;
  localparam int WD     = 150000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n;
  logic              sck;
  logic [3:0]        io_in;
  logic [1:0]        lat_sel;
  logic [3:0]        io_out;
  logic [3:0]        io_oe;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rd_data;
  logic              abort_err;

  int n_chk = 0;
  int n_err = 0;
  int rd_cnt = 0;
  int err_cnt = 0;

  always #10 clk = ~clk;

  qxr_target #(.ADDR_W(ADDR_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sck         (sck),
    .io_in       (io_in),
    .lat_sel     (lat_sel),
    .io_out      (io_out),
    .io_oe       (io_oe),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .abort_err   (abort_err)
  );

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5A;
  endfunction

  function automatic int exp_dummy(input logic [1:0] l);
    return (l == 2'd3) ? 6 : 2 * (int'(l) + 1);
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en === 1'b1) begin
      mem_rd_data <= pat(mem_addr);
      rd_cnt++;
    end
    if (abort_err === 1'b1) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_cyc(input logic [3:0] d, output logic [3:0] smp, output logic [3:0] oe);
    io_in = d;
    tick(HALF);
    smp = io_out;
    oe  = io_oe;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic send_op_bits(input logic [7:0] op, input bit quad);
    logic [3:0] s, o;
    if (quad) begin
      sck_cyc(op[7:4], s, o);
      sck_cyc(op[3:0], s, o);
    end else begin
      for (int i = 7; i >= 0; i--) sck_cyc({3'b000, op[i]}, s, o);
    end
  endtask

  task automatic cs_end();
    io_in = 4'h0;
    tick(HALF);
    cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic send_cmd(input logic [7:0] op, input bit quad);
    cs_n = 1'b0;
    tick(HALF);
    send_op_bits(op, quad);
    cs_end();
  endtask

  // one read transaction; nnib data nibbles are sampled
  task automatic do_read(input bit with_op, input bit quad_op, input logic [23:0] a,
                         input logic [7:0] mode, input logic [1:0] l, input int nnib,
                         input bit expect_data, input string req);
    logic [3:0] s, o, en;
    logic [7:0] b;
    logic [ADDR_W-1:0] ea;
    bit oe_bad;
    int rd0;
    rd0 = rd_cnt;
    oe_bad = 1'b0;
    lat_sel = l;
    cs_n = 1'b0;
    tick(HALF);
    if (with_op) send_op_bits(8'hEB, quad_op);
    for (int i = 5; i >= 0; i--) begin
      sck_cyc(a[i*4 +: 4], s, o);
      if (o != 4'h0) oe_bad = 1'b1;
    end
    for (int i = 1; i >= 0; i--) begin
      sck_cyc(mode[i*4 +: 4], s, o);
      if (o != 4'h0) oe_bad = 1'b1;
    end
    for (int i = 0; i < exp_dummy(l); i++) begin
      sck_cyc(4'h0, s, o);
      if (o != 4'h0) oe_bad = 1'b1;
    end
    chk(!oe_bad, {req, " R4 outputs off before data"}, {31'd0, oe_bad}, 32'd0);
    ea = a[ADDR_W-1:0];
    oe_bad = 1'b0;
    for (int k = 0; k < nnib; k++) begin
      sck_cyc(4'h0, s, o);
      if (expect_data) begin
        b  = pat(ea);
        en = (k % 2 == 0) ? b[7:4] : b[3:0];
        chk(o == 4'hF && s == en, {req, " R5 data nibble"}, {o, s}, {4'hF, en});
        if (k % 2 == 1) ea = ea + 1'b1;
      end else if (o != 4'h0) begin
        oe_bad = 1'b1;
      end
    end
    if (!expect_data) begin
      chk(!oe_bad, {req, " R10 outputs stay off"}, {31'd0, oe_bad}, 32'd0);
      chk(rd_cnt == rd0, {req, " R10 no fetch"}, rd_cnt, rd0);
    end
    cs_end();
    chk(io_oe == 4'h0, {req, " R9 outputs off after select rise"}, {28'd0, io_oe}, 32'd0);
  endtask

  task automatic t_reset();
    chk(io_oe == 4'h0, "R1 reset oe", {28'd0, io_oe}, 32'd0);
    chk(abort_err == 1'b0, "R1 reset err", {31'd0, abort_err}, 32'd0);
    chk(mem_rd_en == 1'b0, "R1 reset rd", {31'd0, mem_rd_en}, 32'd0);
  endtask

  task automatic t_locked();
    do_read(1'b1, 1'b0, 24'h000100, 8'h00, 2'd0, 4, 1'b0, "R10 locked read");
  endtask

  task automatic t_basic();
    int r0;
    send_cmd(8'h05, 1'b0);
    r0 = rd_cnt;
    do_read(1'b1, 1'b0, 24'h000123, 8'h00, 2'd0, 8, 1'b1, "R2 basic read");
    chk(rd_cnt == r0 + 5, "R6 fetch count", rd_cnt, r0 + 5);
  endtask

  task automatic t_upper();
    do_read(1'b1, 1'b0, 24'hF80040, 8'h00, 2'd0, 4, 1'b1, "R3 upper bits ignored");
  endtask

  task automatic t_wrap();
    do_read(1'b1, 1'b0, 24'h07FFFE, 8'h00, 2'd0, 8, 1'b1, "R5 wrap");
  endtask

  task automatic t_latency();
    do_read(1'b1, 1'b0, 24'h001234, 8'h00, 2'd1, 4, 1'b1, "R4 lat1");
    do_read(1'b1, 1'b0, 24'h002345, 8'h00, 2'd2, 4, 1'b1, "R4 lat2");
    do_read(1'b1, 1'b0, 24'h003456, 8'h00, 2'd3, 4, 1'b1, "R4 lat3");
  endtask

  task automatic t_xip();
    do_read(1'b1, 1'b0, 24'h010000, 8'hEF, 2'd0, 4, 1'b1, "R7 enter EF");
    do_read(1'b0, 1'b0, 24'h020304, 8'hAF, 2'd0, 4, 1'b1, "R7 no opcode AF");
    do_read(1'b0, 1'b0, 24'h030405, 8'h12, 2'd0, 4, 1'b1, "R8 no opcode exit");
    do_read(1'b1, 1'b0, 24'h040506, 8'h00, 2'd0, 4, 1'b1, "R8 opcode after exit");
  endtask

  task automatic t_abort();
    logic [3:0] s, o;
    int e0;
    do_read(1'b1, 1'b0, 24'h011111, 8'hEF, 2'd1, 2, 1'b1, "R7 enter before abort");
    e0 = err_cnt;
    lat_sel = 2'd1;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 5; i >= 0; i--) sck_cyc(4'h2, s, o);
    sck_cyc(4'hE, s, o);
    sck_cyc(4'hF, s, o);
    sck_cyc(4'h0, s, o);
    cs_end();
    chk(err_cnt == e0 + 1, "R12 abort pulse", err_cnt, e0 + 1);
    do_read(1'b1, 1'b0, 24'h050607, 8'h00, 2'd0, 4, 1'b1, "R12 xip cleared");
  endtask

  task automatic t_mid_data();
    int e0;
    e0 = err_cnt;
    do_read(1'b1, 1'b0, 24'h060000, 8'h00, 2'd0, 3, 1'b1, "R9 mid data");
    chk(err_cnt == e0, "R9 no error on data stop", err_cnt, e0);
    do_read(1'b1, 1'b0, 24'h060100, 8'h00, 2'd0, 2, 1'b1, "R9 next read");
  endtask

  task automatic t_quad();
    send_cmd(8'h38, 1'b0);
    do_read(1'b1, 1'b1, 24'h070809, 8'h00, 2'd0, 4, 1'b1, "R11 quad opcode");
    send_cmd(8'hFF, 1'b1);
    do_read(1'b1, 1'b0, 24'h0A0B0C, 8'h00, 2'd0, 4, 1'b1, "R11 single opcode again");
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    cs_n    = 1'b1;
    sck     = 1'b0;
    io_in   = 4'h0;
    lat_sel = 2'd0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_locked();
    t_basic();
    t_upper();
    t_wrap();
    t_latency();
    t_xip();
    t_abort();
    t_mid_data();
    t_quad();
    tick(10);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule